// File: doc/BRIEF.md
# Descriptor ring producer with lap stamping

The block accepts fixed-size descriptors on a valid/ready input and writes each one into a circular ring held in internal registers. Every ring entry is eight 32-bit words: the seven payload words come straight from the input, and the final word is filled in by the block with a constant ring identifier and a 4-bit lap counter. The lap counter records how many passes the producer has made around the ring.

A consumer-side poller inside the same block reads the entry at its own read index and decides whether that entry is fresh by comparing the stamped lap bit 0 with the parity it expects on its current pass. No producer head pointer is consulted. When the poller sees a fresh entry it offers it on a valid/ready read port. The producer stops accepting input when the unread entries fill the ring. An occupancy count is also exported.

Top module: `desc_ring_producer`

## Requirements
- R1: Each stored entry is 256 bits. Word i (bits [32i+31:32i], i = 0..6) is word i of the accepted payload. In word 7 (bits [255:224]), bits [31:28] hold the lap stamp, bits [27:20] hold the RING_ID parameter and bits [19:0] are zero.
- R2: After reset `prod_lap` is 0. Every entry written during the producer's first pass is stamped with lap 1, and `prod_lap` shows the stamp of the most recently written entry.
- R3: The lap stamp grows by exactly 1 at the start of each new pass. After 15 it continues at 0, so the 16th pass is stamped 0.
- R4: The write index advances by one per accepted descriptor and wraps from DEPTH-1 to 0. The first entry of the second pass goes to index 0 and carries lap 2.
- R5: `in_ready` is low exactly when DEPTH entries are unread (write and read index equal, pass parities differ). A descriptor offered while `in_ready` is low is not stored and never appears on the read port.
- R6: `out_valid` is high exactly when the entry at the read index has lap bit 0 equal to the poller's expected parity. The expected parity starts at 1 and flips whenever the read index wraps. As a result, `out_valid` is high exactly when `fill_level` is nonzero: no stale entry is offered and no fresh entry is missed.
- R7: Reset clears both indices, the pass parities, the lap counter and every ring entry. After reset `out_entry` is all zero, `out_valid` is 0, `in_ready` is 1 and `fill_level` is 0.
- R8: `fill_level` equals the number of accepted descriptors minus the number of entries read, in the range 0 to DEPTH.
- R9: Entries leave on the read port in the order they were accepted, each exactly once, when `out_valid` and `out_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Ring has room for a descriptor |
| in_desc | input | 224 | Payload words 0..6 of the descriptor |
| out_valid | output | 1 | Entry at the read index is fresh |
| out_ready | input | 1 | Consumer takes the offered entry |
| out_entry | output | 256 | Full stamped entry at the read index |
| fill_level | output | $clog2(DEPTH)+1 | Unread entry count |
| prod_lap | output | 4 | Current lap counter value |

## Verification
The bench runs well over sixteen producer passes, so that the lap stamp has to roll from 15 to 0. A design that saturated the counter or dropped the carry would stamp the wrong value and fail the scoreboard compare. The bench fills the ring and keeps offering descriptors while it is full. A ready signal computed from the index alone would overwrite an unread entry, and the discarded payload would show up in the stream. Empty and full states are crossed repeatedly under random valid/ready patterns. A poller that flipped its parity at the wrong time, or began at 0, would offer zeroed or last-pass entries as new, or would stall on fresh ones. A second reset after traffic catches memory that is left holding stale stamps.

// File: rtl/desc_ring_producer.sv
module desc_ring_producer #(
  parameter int         DEPTH       = 8,
  parameter int         WORD_W      = 32,
  parameter int         ENTRY_WORDS = 8,
  parameter int         LAP_W       = 4,
  parameter int         ID_W        = 8,
  parameter logic [7:0] RING_ID     = 8'hA5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [WORD_W*(ENTRY_WORDS-1)-1:0] in_desc,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [WORD_W*ENTRY_WORDS-1:0]  out_entry,
  output logic [$clog2(DEPTH):0]         fill_level,
  output logic [LAP_W-1:0]               prod_lap
);
  localparam int ENTRY_W = WORD_W * ENTRY_WORDS;
  localparam int PAY_W   = WORD_W * (ENTRY_WORDS - 1);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int LAP_LSB = ENTRY_W - LAP_W;
  localparam int RSV_W   = WORD_W - LAP_W - ID_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] ring_q [DEPTH];
  logic [IDX_W-1:0]   wr_idx_q, rd_idx_q;
  logic               wr_par_q, rd_par_q;
  logic [LAP_W-1:0]   lap_q, lap_next;
  logic [WORD_W-1:0]  stamp_word;
  logic [ENTRY_W-1:0] head;
  logic               push, pop, full;

  // ring is full when the producer is one pass ahead at the same index
  assign full       = (wr_idx_q == rd_idx_q) && (wr_par_q != rd_par_q);
  assign in_ready   = !full;
  assign push       = in_valid && in_ready;
  assign pop        = out_valid && out_ready;

  // a pass begins when index 0 is written
  assign lap_next   = (wr_idx_q == '0) ? lap_q + 1'b1 : lap_q;
  assign stamp_word = {lap_next, ID_W'(RING_ID), {RSV_W{1'b0}}};

  assign head       = ring_q[rd_idx_q];
  assign out_entry  = head;
  assign out_valid  = head[LAP_LSB] == ~rd_par_q;
  assign fill_level = {wr_par_q, wr_idx_q} - {rd_par_q, rd_idx_q};
  assign prod_lap   = lap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
      wr_idx_q <= '0;
      wr_par_q <= 1'b0;
      lap_q    <= '0;
    end else if (push) begin
      ring_q[wr_idx_q] <= {stamp_word, in_desc[PAY_W-1:0]};
      lap_q            <= lap_next;
      wr_idx_q         <= wr_idx_q + 1'b1;
      if (wr_idx_q == LAST_IDX) wr_par_q <= ~wr_par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q <= '0;
      rd_par_q <= 1'b0;
    end else if (pop) begin
      rd_idx_q <= rd_idx_q + 1'b1;
      if (rd_idx_q == LAST_IDX) rd_par_q <= ~rd_par_q;
    end
  end
endmodule

// File: rtl/desc_ring_producer_chk.sv
module desc_ring_producer_chk #(
  parameter int         DEPTH   = 8,
  parameter int         LAP_W   = 4,
  parameter logic [7:0] RING_ID = 8'hA5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [255:0]           out_entry,
  input logic [$clog2(DEPTH):0] fill_level,
  input logic [LAP_W-1:0]       prod_lap
);
  localparam int FW = $clog2(DEPTH) + 1;

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= FW'(DEPTH));

  // R8
  fill_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> fill_level == $past(fill_level) + 1'b1);

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == FW'(DEPTH)) |-> !in_ready);

  // R6
  no_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill_level != '0);

  // R6
  no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level != '0) |-> out_valid);

  // R1
  stamp_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_entry[243:224] == '0 && out_entry[251:244] == RING_ID));

  // R3
  lap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_lap) |-> prod_lap == $past(prod_lap) + 1'b1);
endmodule

bind desc_ring_producer desc_ring_producer_chk #(
  .DEPTH(DEPTH), .LAP_W(LAP_W), .RING_ID(RING_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_entry(out_entry),
  .fill_level(fill_level), .prod_lap(prod_lap)
);

// File: tb/desc_ring_producer_bench.sv
module desc_ring_producer_bench;
  localparam int         DEPTH = 8;
  localparam logic [7:0] RID   = 8'hA5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [223:0] in_desc = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [255:0] out_entry;
  logic [3:0]   fill_level;
  logic [3:0]   prod_lap;

  always #4 clk = ~clk;

  desc_ring_producer #(.DEPTH(DEPTH), .RING_ID(RID)) u_desc_ring_producer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .out_valid(out_valid), .out_ready(out_ready),
    .out_entry(out_entry), .fill_level(fill_level), .prod_lap(prod_lap)
  );

  logic [255:0] sb[$];
  int pushes = 0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit saw_wrap = 0;
  logic [31:0] lfsr = 32'h1234ABCD;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] exp_lap(input int n);
    if (n == 0) return 4'd0;
    return 4'(((n - 1) / DEPTH + 1) % 16);
  endfunction

  function automatic logic [255:0] mk_entry(input int n, input logic [223:0] pay);
    return {4'((n / DEPTH + 1) % 16), RID, 20'h0, pay};
  endfunction

  // one clock: monitor compares state, driver applies inputs and updates the model
  task automatic cycle(input bit v, input bit r);
    @(negedge clk);
    chk(fill_level == 4'(sb.size()), "R8", "fill_level", 256'(fill_level), 256'(sb.size()));
    chk(out_valid == (sb.size() > 0), "R6", "out_valid", 256'(out_valid), 256'(sb.size() > 0));
    chk(in_ready == (sb.size() < DEPTH), "R5", "in_ready", 256'(in_ready), 256'(sb.size() < DEPTH));
    chk(prod_lap == exp_lap(pushes), "R2", "prod_lap", 256'(prod_lap), 256'(exp_lap(pushes)));
    if (pushes > 16 * DEPTH && prod_lap == 4'd0) saw_wrap = 1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    in_valid = v;
    out_ready = r;
    for (int i = 0; i < 7; i++)
      in_desc[32*i +: 32] = lfsr ^ (32'h01010101 * i) ^ 32'(pushes);
    #1;
    if (out_valid && out_ready) begin
      if (sb.size() > 0) begin
        // R9 order, R1 layout
        chk(out_entry == sb[0], "R9", "out_entry", out_entry, sb[0]);
        void'(sb.pop_front());
      end else begin
        chk(1'b0, "R6", "pop from empty", 256'(out_valid), 256'(0));
      end
    end
    if (in_valid && in_ready) begin
      sb.push_back(mk_entry(pushes, in_desc));
      pushes++;
    end
  endtask

  task automatic reset_checks();
    @(negedge clk);
    chk(out_entry == '0, "R7", "entry after reset", out_entry, 256'(0));
    chk(!out_valid, "R7", "out_valid after reset", 256'(out_valid), 256'(0));
    chk(in_ready, "R7", "in_ready after reset", 256'(in_ready), 256'(1));
    chk(fill_level == 0, "R7", "fill after reset", 256'(fill_level), 256'(0));
    chk(prod_lap == 0, "R2", "lap after reset", 256'(prod_lap), 256'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    reset_checks();

    // R5: fill the ring, then keep offering while full
    repeat (DEPTH) cycle(1, 0);
    repeat (6) cycle(1, 0);
    chk(pushes == DEPTH, "R5", "accepted while full", 256'(pushes), 256'(DEPTH));

    // R9: drain in order
    repeat (DEPTH + 2) cycle(0, 1);

    // R4: next write lands at index 0 of pass two
    cycle(1, 0);
    cycle(0, 0);
    chk(out_valid && out_entry[255:252] == 4'd2, "R4", "second pass head",
        256'(out_entry[255:252]), 256'(2));
    chk(out_entry[243:224] == '0 && out_entry[251:244] == RID, "R1", "stamp word",
        256'(out_entry[255:224]), {224'(0), 4'd2, RID, 20'h0});

    // random traffic, many passes
    for (int k = 0; k < 2500; k++) cycle(lfsr[3] | lfsr[7], lfsr[11] | lfsr[13]);
    for (int k = 0; k < 400; k++)  cycle(1, lfsr[5] & lfsr[9]);
    for (int k = 0; k < 400; k++)  cycle(lfsr[4] & lfsr[8], 1);
    repeat (DEPTH + 2) cycle(0, 1);

    // R3: the counter rolled past 15
    chk(saw_wrap, "R3", "lap wrapped to 0", 256'(saw_wrap), 256'(1));
    chk(pushes > 17 * DEPTH, "R3", "passes driven", 256'(pushes), 256'(17 * DEPTH));

    // R7: reset after traffic clears the memory
    repeat (DEPTH / 2) cycle(1, 0);
    @(negedge clk) rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    sb.delete();
    pushes = 0;
    reset_checks();
    repeat (3) cycle(1, 1);
    repeat (4) cycle(0, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule